// File: doc/BRIEF.md
# Timer Output Flip-Flop Controller

This block is a free-running up-counter with two compare slots, two capture slots and a single output flip-flop that drives a pin. The counter advances by one on each cycle its enable is high and returns to zero on a synchronous clear. Each compare slot is loaded from a shared data bus and flags a hit when the counter reaches its value. Each capture slot copies the counter on a strobe. Any of these four hardware events can toggle the output flip-flop, and each one has its own enable.

A byte-wide control register holds the four event enables and carries a two-bit command that software uses to toggle, set or clear the flip-flop directly. The command is not stored, so every write must carry the full set of enables; read-modify-write is not meaningful. The command bits and the two top bits always read back as ones.

Top module: `tmr_outff_timer`

## Requirements
- R1: After reset the counter is 0. With cnt_clr high it becomes 0 at the next edge regardless of cnt_en; otherwise with cnt_en high it increases by one per edge, and with cnt_en low it holds.
- R2: When the counter holds a freshly reached value equal to compare slot 0 and control bit 2 is 1, the output flip-flop toggles at the next edge.
- R3: When the counter holds a freshly reached value equal to compare slot 1 and control bit 3 is 1, the output flip-flop toggles at the next edge.
- R4: A strobe on cap_stb[i] copies the current counter into capture slot i at the next edge; in that same edge the flip-flop toggles if the slot's enable (bit 4 for slot 0, bit 5 for slot 1) is 1.
- R5: All four enables reset to 0; an event whose enable is 0 leaves the flip-flop unchanged (a capture still records the counter).
- R6: Control bits 1:0 form a one-shot command acting at the edge of the write: 00 toggles, 01 sets to 1, 10 clears to 0, 11 does nothing.
- R7: A control read returns bits 7:6 and 1:0 as 1 and bits 5:2 as the stored enables (0xC3 after reset); every write replaces all four enables, which take effect from the cycle after the write.
- R8: A set or clear command overrides hardware events in the same cycle; toggles from the command and from hardware events combine by parity, so an even number of them leaves the flip-flop unchanged.
- R9: A compare hit counts once per counter value: a counter held stopped on a matching value does not toggle the flip-flop again. A value is fresh in the cycle after the counter stepped or was cleared.
- R10: The output flip-flop is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter step enable |
| cnt_clr | input | 1 | Synchronous counter clear |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control read data |
| cmp_ld | input | 2 | Load strobe per compare slot |
| cmp_wdata | input | CNT_W | Compare load value |
| cap_stb | input | 2 | Capture strobe per capture slot |
| count | output | CNT_W | Current counter value |
| cap_val | output | 2*CNT_W | Capture slots, slot 1 in the upper half |
| tff_out | output | 1 | Output flip-flop pin |

## Verification
The flip-flop is driven by each event source alone, so a toggle that happens can be tied to the one source that caused it, and by the same source with its enable low to separate gating from detection. Paired events in one cycle (two equal compare slots, capture plus toggle command) separate parity combining from a plain OR, and a set or clear issued against an opposing capture toggle shows which source has priority. A counter parked on a matching value for several cycles distinguishes per-value detection from level detection.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMD_TOGGLE = 2'b00,
    CMD_SET    = 2'b01,
    CMD_CLEAR  = 2'b10,
    CMD_NONE   = 2'b11
  } ffcmd_e;

  localparam int CTRL_W   = 8;
  localparam int N_EVT    = 4;   // m0, m1, c0, c1
  localparam int EN_LSB   = 2;   // enables occupy bits 5:2
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= en | clr;
      if (clr)     count <= '0;
      else if (en) count <= count + 1'b1;
    end
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!clr && en) |=> (count == $past(count) + 1'b1));
  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> (!fresh && $stable(count)));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] count,
  input  logic         fresh,
  output logic         hit
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)     ref_q <= '0;
    else if (ld) ref_q <= ld_val;
  end

  assign hit = fresh && (count == ref_q);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (ref_q == $past(ld_val)));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (rst)      cap_q <= '0;
    else if (stb) cap_q <= count;
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    stb |=> (cap_q == $past(count)));
endmodule

// File: rtl/tmr_outff.sv
module tmr_outff
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [CTRL_W-1:0]   wdata,
  input  logic [N_EVT-1:0]    evt,
  output logic [N_EVT-1:0]    en_q,
  output logic                tff
);
  ffcmd_e           cmd;
  logic [N_EVT-1:0] gated;
  logic             flip;
  logic             tff_d;

  assign cmd   = ffcmd_e'(wdata[1:0]);
  assign gated = evt & en_q;
  assign flip  = (^gated) ^ (wr && cmd == CMD_TOGGLE);

  always_comb begin
    tff_d = tff ^ flip;
    if (wr && cmd == CMD_SET)   tff_d = 1'b1;
    if (wr && cmd == CMD_CLEAR) tff_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      tff  <= 1'b0;
    end else begin
      if (wr) en_q <= wdata[EN_LSB +: N_EVT];
      tff <= tff_d;
    end
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[1:0] == 2'b01) |=> tff);
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[1:0] == 2'b10) |=> !tff);
  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr && (evt & en_q) == '0) |=> $stable(tff));
  assert_enables_R7: assert property (@(posedge clk) disable iff (rst)
    wr |=> (en_q == $past(wdata[5:2])));
endmodule

// File: rtl/tmr_outff_timer.sv
module tmr_outff_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               cnt_clr,
  input  logic               ctrl_wr,
  input  logic [7:0]         ctrl_wdata,
  output logic [7:0]         ctrl_rdata,
  input  logic [1:0]         cmp_ld,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [1:0]         cap_stb,
  output logic [CNT_W-1:0]   count,
  output logic [2*CNT_W-1:0] cap_val,
  output logic               tff_out
);
  localparam int N_SLOT = 2;

  logic              fresh;
  logic [N_SLOT-1:0] hit;
  logic [N_EVT-1:0]  en_q;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .clr(cnt_clr),
    .count(count), .fresh(fresh)
  );

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    tmr_match #(.W(CNT_W)) u_match (
      .clk(clk), .rst(rst), .ld(cmp_ld[i]), .ld_val(cmp_wdata),
      .count(count), .fresh(fresh), .hit(hit[i])
    );
    tmr_capture #(.W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .stb(cap_stb[i]), .count(count),
      .cap_q(cap_val[i*CNT_W +: CNT_W])
    );
  end

  tmr_outff u_ff (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .evt({cap_stb, hit}), .en_q(en_q), .tff(tff_out)
  );

  assign ctrl_rdata = {2'b11, en_q, 2'b11};
endmodule

// File: tb/tb_tmr_outff_timer.sv
module tb_tmr_outff_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0, cnt_clr = 1'b0, ctrl_wr = 1'b0;
  logic [7:0]   ctrl_wdata = 8'h03;
  logic [7:0]   ctrl_rdata;
  logic [1:0]   cmp_ld = 2'b00, cap_stb = 2'b00;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] count;
  logic [2*W-1:0] cap_val;
  logic         tff_out;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_outff_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .cmp_ld(cmp_ld), .cmp_wdata(cmp_wdata), .cap_stb(cap_stb),
    .count(count), .cap_val(cap_val), .tff_out(tff_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d; cyc(); ctrl_wr = 1'b0;
  endtask
  task automatic run(input int n); cnt_en = 1'b1; repeat (n) cyc(); cnt_en = 1'b0; endtask
  task automatic clr_cnt(); cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0; endtask
  task automatic ld_cmp(input logic [1:0] sel, input logic [W-1:0] v);
    cmp_ld = sel; cmp_wdata = v; cyc(); cmp_ld = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 count after reset", int'(count), 0);
    chk("R10 tff after reset", int'(tff_out), 0);
    chk("R7 rdata after reset", int'(ctrl_rdata), 8'hC3);
  endtask

  task automatic t_counter();
    run(5);
    chk("R1 count after 5 steps", int'(count), 5);
    repeat (3) cyc();
    chk("R1 count held", int'(count), 5);
    cnt_en = 1'b1; cnt_clr = 1'b1; cyc(); cnt_en = 1'b0; cnt_clr = 1'b0;
    chk("R1 clear over enable", int'(count), 0);
  endtask

  task automatic t_cmd();
    wr_ctrl(8'h01); chk("R6 set", int'(tff_out), 1);
    wr_ctrl(8'h03); chk("R6 none", int'(tff_out), 1);
    wr_ctrl(8'h00); chk("R6 toggle", int'(tff_out), 0);
    wr_ctrl(8'h00); chk("R6 toggle back", int'(tff_out), 1);
    repeat (2) cyc(); chk("R6 one shot", int'(tff_out), 1);
    wr_ctrl(8'h02); chk("R6 clear", int'(tff_out), 0);
  endtask

  task automatic t_readback();
    wr_ctrl(8'h3D);
    chk("R7 rdata all enables", int'(ctrl_rdata), 8'hFF);
    chk("R6 set with enables", int'(tff_out), 1);
    wr_ctrl(8'h03);
    chk("R7 rdata replaced", int'(ctrl_rdata), 8'hC3);
    wr_ctrl(8'h02);
  endtask

  task automatic t_match();
    ld_cmp(2'b01, 16'd5);
    wr_ctrl(8'h07);
    clr_cnt();
    run(5);
    chk("R2 count at match", int'(count), 5);
    chk("R2 tff before toggle", int'(tff_out), 0);
    cyc();
    chk("R2 match0 toggle", int'(tff_out), 1);
    repeat (3) cyc();
    chk("R9 held counter once", int'(tff_out), 1);
    wr_ctrl(8'h03);
    clr_cnt(); run(5); repeat (2) cyc();
    chk("R5 match0 disabled", int'(tff_out), 1);
    ld_cmp(2'b10, 16'd7);
    wr_ctrl(8'h0B);
    clr_cnt(); run(7); cyc();
    chk("R3 match1 toggle", int'(tff_out), 0);
    ld_cmp(2'b11, 16'd9);
    wr_ctrl(8'h0F);
    clr_cnt(); run(9); repeat (2) cyc();
    chk("R8 two matches cancel", int'(tff_out), 0);
  endtask

  task automatic t_capture();
    wr_ctrl(8'h13);
    clr_cnt(); run(3);
    cap_stb = 2'b01; cyc(); cap_stb = 2'b00;
    chk("R4 cap0 value", int'(cap_val[W-1:0]), 3);
    chk("R4 cap0 toggle", int'(tff_out), 1);
    cap_stb = 2'b10; cyc(); cap_stb = 2'b00;
    chk("R4 cap1 value", int'(cap_val[2*W-1:W]), 3);
    chk("R5 cap1 disabled", int'(tff_out), 1);
    wr_ctrl(8'h23);
    run(2);
    cap_stb = 2'b10; cyc(); cap_stb = 2'b00;
    chk("R4 cap1 value 5", int'(cap_val[2*W-1:W]), 5);
    chk("R4 cap1 toggle", int'(tff_out), 0);
  endtask

  task automatic t_priority();
    wr_ctrl(8'h11);
    chk("R8 setup set", int'(tff_out), 1);
    ctrl_wr = 1'b1; ctrl_wdata = 8'h11; cap_stb = 2'b01; cyc();
    ctrl_wr = 1'b0; cap_stb = 2'b00;
    chk("R8 set beats capture", int'(tff_out), 1);
    wr_ctrl(8'h12);
    ctrl_wr = 1'b1; ctrl_wdata = 8'h12; cap_stb = 2'b01; cyc();
    ctrl_wr = 1'b0; cap_stb = 2'b00;
    chk("R8 clear beats capture", int'(tff_out), 0);
    ctrl_wr = 1'b1; ctrl_wdata = 8'h10; cap_stb = 2'b01; cyc();
    ctrl_wr = 1'b0; cap_stb = 2'b00;
    chk("R8 toggle plus capture cancel", int'(tff_out), 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_counter();
    t_cmd();
    t_readback();
    t_match();
    t_capture();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule